// File: doc/BRIEF.md
# Multi-Mode 3x3 Spatial Filter

This block is a streaming 3x3 neighbourhood filter for 8-bit pixels that arrive in raster order, at most one per clock. Two line memories hold the two previous lines of the frame, and a small shift chain holds the two previous columns. Together they form a 3x3 window every time a pixel is accepted. Four fixed kernels are evaluated on that window in parallel: box average, gradient magnitude, relief and sharpening. A mode input picks one of them, or a pass-through of the window centre. All results take the same path through the pipeline, so changing the mode never moves the output in time.

The window covers the current line and the two lines before it, and the current column and the two columns before it. The output for an accepted pixel is therefore the filtered value of the pixel one line up and one column left. Where the window reaches above the first line or left of the first column of a frame, it reuses the nearest pixel inside the image. The line-start and frame-start markers travel with their pixel and come out with its result.

Top module: `conv3x3_filter`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, valid_o, hsync_o and vsync_o are 0 and pix_o is 0.
- R2: Each cycle with valid_i high produces exactly one cycle with valid_o high, 3 clocks later, whatever the mode. hsync_o and vsync_o equal hsync_i and vsync_i of that pixel, each gated by valid_i.
- R3: hsync_i marks the first pixel of a line and vsync_i the first pixel of a frame (sent together with hsync_i). For the accepted pixel at line r and column c, the window entry at row i and column j (0..2, top-left first) is pixel (max(r-2+i,0), max(c-2+j,0)) of the same frame. Window positions above or left of the image therefore repeat the edge pixel.
- R4: Mode code 0, and the unused codes 5 to 7, output the window centre unchanged.
- R5: Mode code 1 outputs the floor of the sum of all nine window pixels divided by 8, saturated to 255.
- R6: Mode code 2 outputs |Gx|+|Gy| saturated to 255. Gx is the right column minus the left column with weights 1,2,1 from top to bottom. Gy is the bottom row minus the top row with weights 1,2,1 from left to right. A flat window gives 0.
- R7: Mode code 3 outputs 128 plus the window weighted by rows [-2 -1 0], [-1 1 1], [0 1 2], clamped to 0..255.
- R8: Mode code 4 outputs five times the centre minus its four edge neighbours, clamped to 0..255.
- R9: In a cycle with valid_o low, pix_o keeps the value it had in the previous cycle.
- R10: Cycles with valid_i low change neither the window nor the line and column positions. A stream with idle gaps gives the same outputs as the same stream without gaps.
- R11: The mode is sampled on the clock edge that loads the output register, so a change of mode between frames takes effect without any change in latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Result select: 0 pass, 1 average, 2 gradient, 3 relief, 4 sharpen |
| valid_i | input | 1 | Input pixel valid |
| hsync_i | input | 1 | First pixel of a line |
| vsync_i | input | 1 | First pixel of a frame |
| pix_i | input | 8 | Input pixel |
| valid_o | output | 1 | Output pixel valid |
| hsync_o | output | 1 | Delayed line-start marker |
| vsync_o | output | 1 | Delayed frame-start marker |
| pix_o | output | 8 | Filtered pixel |

## Verification
The hardest case to reach is the second line and second column of a frame. There the window mixes line-memory data, shift-chain data and replicated edge pixels, and an off-by-one in the row or column clamp only shows up as a wrong neighbour in one kernel. The stimulus runs short frames of a reduced line width, so every frame spends most of its pixels near the top and left borders. It uses ramps, random data and a 0/255 checkerboard in every mode, so that a swapped neighbour changes the result and the saturation limits are reached. Some frames insert random idle cycles between pixels, which checks that the window holds its state across gaps.

// File: rtl/conv3x3_pkg.sv
`timescale 1ns/1ps
package conv3x3_pkg;
  localparam int NUM_RES = 5;  // pass + four kernels, indexed by mode code
  localparam logic [2:0] MODE_PASS   = 3'd0;
  localparam logic [2:0] MODE_BLUR   = 3'd1;
  localparam logic [2:0] MODE_EDGE   = 3'd2;
  localparam logic [2:0] MODE_EMBOSS = 3'd3;
  localparam logic [2:0] MODE_SHARP  = 3'd4;
endpackage

// File: rtl/conv3x3_linebuf.sv
`timescale 1ns/1ps
module conv3x3_linebuf #(
  parameter int DEPTH = 960,
  parameter int DW    = 8
) (
  input  logic                   clk_i,
  input  logic                   we_i,
  input  logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] addr_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [DW-1:0]          rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  // read returns the old word at the address being written this cycle
  assign rdata_o = mem_q[addr_i];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end
endmodule

// File: rtl/conv3x3_window.sv
`timescale 1ns/1ps
module conv3x3_window #(
  parameter int W  = 960,
  parameter int DW = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               hsync_i,
  input  logic               vsync_i,
  input  logic [DW-1:0]      pix_i,
  output logic [8:0][DW-1:0] win_o,
  output logic               valid_o,
  output logic               hsync_o,
  output logic               vsync_o
);
  localparam int AW  = (W > 1) ? $clog2(W) : 1;
  localparam int NLB = 2;

  logic [AW-1:0] col_q, cur_col;
  logic [1:0]    row_q, cur_row;

  always_comb begin
    cur_col = hsync_i ? '0 : col_q;
    if (vsync_i)      cur_row = 2'd0;
    else if (hsync_i) cur_row = (row_q == 2'd2) ? 2'd2 : row_q + 2'd1;
    else              cur_row = row_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= '0;
    end else if (valid_i) begin
      row_q <= cur_row;
      col_q <= (cur_col == AW'(W-1)) ? cur_col : cur_col + 1'b1;
    end
  end

  logic [DW-1:0] lb_wr [NLB];
  logic [DW-1:0] lb_rd [NLB];

  for (genvar g = 0; g < NLB; g++) begin : g_lb
    if (g == 0) begin : g_first
      assign lb_wr[g] = pix_i;
    end else begin : g_chain
      assign lb_wr[g] = lb_rd[g-1];
    end
    conv3x3_linebuf #(.DEPTH(W), .DW(DW)) u_lb (
      .clk_i  (clk_i),
      .we_i   (valid_i),
      .addr_i (cur_col),
      .wdata_i(lb_wr[g]),
      .rdata_o(lb_rd[g])
    );
  end

  // column vectors, index 0 = top row
  logic [2:0][DW-1:0] cv_cur, cv_d1, cv_d2, cv_left, cv_mid;

  always_comb begin
    cv_cur[2] = pix_i;
    cv_cur[1] = (cur_row == 2'd0) ? pix_i : lb_rd[0];
    cv_cur[0] = (cur_row == 2'd0) ? pix_i :
                (cur_row == 2'd1) ? lb_rd[0] : lb_rd[1];
    cv_left   = (cur_col == '0) ? cv_cur :
                (cur_col == AW'(1)) ? cv_d1 : cv_d2;
    cv_mid    = (cur_col == '0) ? cv_cur : cv_d1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cv_d1   <= '0;
      cv_d2   <= '0;
      win_o   <= '0;
      valid_o <= 1'b0;
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      hsync_o <= hsync_i & valid_i;
      vsync_o <= vsync_i & valid_i;
      if (valid_i) begin
        cv_d1 <= cv_cur;
        cv_d2 <= cv_d1;
        for (int r = 0; r < 3; r++) begin
          win_o[3*r]   <= cv_left[r];
          win_o[3*r+1] <= cv_mid[r];
          win_o[3*r+2] <= cv_cur[r];
        end
      end
    end
  end
endmodule

// File: rtl/conv3x3_kernels.sv
`timescale 1ns/1ps
module conv3x3_kernels
  import conv3x3_pkg::*;
#(
  parameter int DW = 8,
  parameter int KW = DW + 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [8:0][DW-1:0]         win_i,
  input  logic                       valid_i,
  input  logic                       hsync_i,
  input  logic                       vsync_i,
  output logic [NUM_RES-1:0][KW-1:0] res_o,
  output logic                       valid_o,
  output logic                       hsync_o,
  output logic                       vsync_o
);
  logic signed [KW-1:0] p [9];
  logic signed [KW-1:0] sum, gx, gy, agx, agy;
  logic [NUM_RES-1:0][KW-1:0] res_d;

  always_comb begin
    for (int k = 0; k < 9; k++) p[k] = $signed({{(KW-DW){1'b0}}, win_i[k]});
    sum = p[0] + p[1] + p[2] + p[3] + p[4] + p[5] + p[6] + p[7] + p[8];
    gx  = (p[2] + p[5] + p[5] + p[8]) - (p[0] + p[3] + p[3] + p[6]);
    gy  = (p[6] + p[7] + p[7] + p[8]) - (p[0] + p[1] + p[1] + p[2]);
    agx = gx[KW-1] ? -gx : gx;
    agy = gy[KW-1] ? -gy : gy;
    res_d[MODE_PASS]   = p[4];
    res_d[MODE_BLUR]   = sum >>> 3;
    res_d[MODE_EDGE]   = agx + agy;
    res_d[MODE_EMBOSS] = p[4] + p[5] + p[7] + p[8] + p[8]
                       - p[0] - p[0] - p[1] - p[3] + KW'(128);
    res_d[MODE_SHARP]  = p[4] + p[4] + p[4] + p[4] + p[4]
                       - p[1] - p[3] - p[5] - p[7];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o   <= '0;
      valid_o <= 1'b0;
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
    end else begin
      res_o   <= res_d;
      valid_o <= valid_i;
      hsync_o <= hsync_i;
      vsync_o <= vsync_i;
    end
  end
endmodule

// File: rtl/conv3x3_outsel.sv
`timescale 1ns/1ps
module conv3x3_outsel
  import conv3x3_pkg::*;
#(
  parameter int DW = 8,
  parameter int KW = DW + 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [2:0]                 mode_i,
  input  logic [NUM_RES-1:0][KW-1:0] res_i,
  input  logic                       valid_i,
  input  logic                       hsync_i,
  input  logic                       vsync_i,
  output logic [DW-1:0]              pix_o,
  output logic                       valid_o,
  output logic                       hsync_o,
  output logic                       vsync_o
);
  localparam logic signed [KW-1:0] MAXV = KW'((1 << DW) - 1);

  function automatic logic [DW-1:0] sat(input logic signed [KW-1:0] v);
    if (v[KW-1])    return '0;
    else if (v > MAXV) return '1;
    else            return v[DW-1:0];
  endfunction

  logic [KW-1:0] pick;

  always_comb begin
    if (int'(mode_i) < NUM_RES) pick = res_i[mode_i];
    else                        pick = res_i[MODE_PASS];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o   <= '0;
      valid_o <= 1'b0;
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      hsync_o <= hsync_i;
      vsync_o <= vsync_i;
      if (valid_i) pix_o <= sat($signed(pick));
    end
  end
endmodule

// File: rtl/conv3x3_filter.sv
`timescale 1ns/1ps
module conv3x3_filter
  import conv3x3_pkg::*;
#(
  parameter int W  = 960,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    mode_i,
  input  logic          valid_i,
  input  logic          hsync_i,
  input  logic          vsync_i,
  input  logic [DW-1:0] pix_i,
  output logic          valid_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic [DW-1:0] pix_o
);
  localparam int KW = DW + 5;

  logic [8:0][DW-1:0]         win;
  logic                       w_valid, w_hs, w_vs;
  logic [NUM_RES-1:0][KW-1:0] res;
  logic                       k_valid, k_hs, k_vs;

  conv3x3_window #(.W(W), .DW(DW)) u_win (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .valid_i(valid_i), .hsync_i(hsync_i), .vsync_i(vsync_i), .pix_i(pix_i),
    .win_o(win), .valid_o(w_valid), .hsync_o(w_hs), .vsync_o(w_vs)
  );

  conv3x3_kernels #(.DW(DW), .KW(KW)) u_ker (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .win_i(win), .valid_i(w_valid), .hsync_i(w_hs), .vsync_i(w_vs),
    .res_o(res), .valid_o(k_valid), .hsync_o(k_hs), .vsync_o(k_vs)
  );

  conv3x3_outsel #(.DW(DW), .KW(KW)) u_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i),
    .res_i(res), .valid_i(k_valid), .hsync_i(k_hs), .vsync_i(k_vs),
    .pix_o(pix_o), .valid_o(valid_o), .hsync_o(hsync_o), .vsync_o(vsync_o)
  );
endmodule

// File: rtl/conv3x3_chk.sv
`timescale 1ns/1ps
module conv3x3_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic          hsync_i,
  input logic          vsync_i,
  input logic          valid_o,
  input logic          hsync_o,
  input logic          vsync_o,
  input logic [DW-1:0] pix_o
);
  p_valid_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i, 3));

  p_hsync_align_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_o == $past(hsync_i & valid_i, 3));

  p_vsync_align_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_o == $past(vsync_i & valid_i, 3));

  p_hold_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(pix_o));

  p_marker_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hsync_o | vsync_o) |-> valid_o);
endmodule

bind conv3x3_filter conv3x3_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .valid_i(valid_i), .hsync_i(hsync_i), .vsync_i(vsync_i),
  .valid_o(valid_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .pix_o(pix_o)
);

// File: tb/sim_conv3x3_filter.sv
`timescale 1ns/1ps
module sim_conv3x3_filter;
  localparam int W = 8;
  localparam int H = 5;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] mode_i = '0;
  logic       valid_i = 1'b0, hsync_i = 1'b0, vsync_i = 1'b0;
  logic [7:0] pix_i = '0;
  logic       valid_o, hsync_o, vsync_o;
  logic [7:0] pix_o;

  always #2 clk = ~clk;

  conv3x3_filter #(.W(W), .DW(8)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i),
    .valid_i(valid_i), .hsync_i(hsync_i), .vsync_i(vsync_i), .pix_i(pix_i),
    .valid_o(valid_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .pix_o(pix_o)
  );

  typedef struct {
    int    pix;
    bit    hs;
    bit    vs;
    int    due;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   n_run = 0, n_fail = 0, cyc = 0;
  int   img [H][W];
  int   last_pix = 0;
  bit   seen_out = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic int clamp8(input int v);
    return (v < 0) ? 0 : (v > 255) ? 255 : v;
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int ref_px(input int mode, input int r, input int c);
    int w [9];
    int gx, gy, s;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++) begin
        int rr = (r - 2 + i < 0) ? 0 : r - 2 + i;
        int cc = (c - 2 + j < 0) ? 0 : c - 2 + j;
        w[3*i+j] = img[rr][cc];
      end
    case (mode)
      1: begin
        s = 0;
        for (int k = 0; k < 9; k++) s += w[k];
        return clamp8(s / 8);
      end
      2: begin
        gx = (w[2] + 2*w[5] + w[8]) - (w[0] + 2*w[3] + w[6]);
        gy = (w[6] + 2*w[7] + w[8]) - (w[0] + 2*w[1] + w[2]);
        return clamp8(iabs(gx) + iabs(gy));
      end
      3: return clamp8(128 - 2*w[0] - w[1] - w[3] + w[4] + w[5] + w[7] + 2*w[8]);
      4: return clamp8(5*w[4] - w[1] - w[3] - w[5] - w[7]);
      default: return w[4];
    endcase
  endfunction

  function automatic string mode_req(input int mode);
    case (mode)
      1: return "R5";
      2: return "R6";
      3: return "R7";
      4: return "R8";
      default: return "R4";
    endcase
  endfunction

  task automatic fill(input int kind);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++)
        case (kind)
          0: img[r][c] = (r * 37 + c * 11) & 255;
          1: img[r][c] = 100;
          2: img[r][c] = ((r + c) % 2) ? 255 : 0;
          3: img[r][c] = int'($urandom_range(0, 255));
          default: img[r][c] = (c % 3 == 0) ? 250 : 5;
        endcase
  endtask

  // driver: one frame, expected results pushed to the scoreboard
  task automatic run_frame(input int mode, input int kind, input bit gaps);
    string tag;
    @(negedge clk);
    mode_i = 3'(mode);
    fill(kind);
    tag = $sformatf("%s %s R11", mode_req(mode), gaps ? "R10" : "R3");
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        if (gaps && ($urandom_range(0, 2) == 0)) begin
          valid_i = 1'b0; hsync_i = 1'b0; vsync_i = 1'b0;
          pix_i = 8'($urandom_range(0, 255));
          @(negedge clk);
        end
        valid_i = 1'b1;
        hsync_i = (c == 0);
        vsync_i = (r == 0 && c == 0);
        pix_i   = 8'(img[r][c]);
        exp_q.push_back('{ref_px(mode, r, c), (c == 0), (r == 0 && c == 0),
                          cyc + 3, tag});
        @(negedge clk);
      end
    valid_i = 1'b0; hsync_i = 1'b0; vsync_i = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_ni) begin
      if (valid_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected output", int'(pix_o), -1);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(cyc == e.due, "R2 latency", cyc, e.due);
          check(int'(pix_o) == e.pix, e.req, int'(pix_o), e.pix);
          check(hsync_o == e.hs, "R2 hsync", int'(hsync_o), int'(e.hs));
          check(vsync_o == e.vs, "R2 vsync", int'(vsync_o), int'(e.vs));
        end
        last_pix = int'(pix_o);
        seen_out = 1'b1;
      end else begin
        if (seen_out) check(int'(pix_o) == last_pix, "R9 hold", int'(pix_o), last_pix);
        if (exp_q.size() != 0 && exp_q[0].due < cyc)
          check(1'b0, "R2 missing output", 0, exp_q[0].due);
      end
    end
  end

  initial begin
    #1;
    check(valid_o == 1'b0 && pix_o == 8'd0, "R1 reset pix/valid", int'(pix_o), 0);
    check(hsync_o == 1'b0 && vsync_o == 1'b0, "R1 reset markers",
          int'({hsync_o, vsync_o}), 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(valid_o == 1'b0 && pix_o == 8'd0, "R1 after release", int'(pix_o), 0);

    for (int m = 0; m < 5; m++)
      for (int k = 0; k < 5; k++)
        run_frame(m, k, (k % 2) == 1);
    run_frame(6, 0, 1'b0);
    run_frame(7, 3, 1'b1);
    run_frame(5, 2, 1'b0);
    run_frame(2, 1, 1'b1);
    run_frame(4, 2, 1'b1);

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R2 drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule